// File: doc/BRIEF.md
# Serial Bus Response Receiver

This block takes in the reply that a slave sends back on a shared, bidirectional serial data line once the master has finished its command and released the line. It generates the serial clock itself: one pulse for each bit. It samples the wire once per pulse and inverts the level, because the line is active low. It first hunts for a start bit, and the hunt is bounded. It then reads a short header that carries the responding slave's address and a two-bit response tag. If the tag is an acknowledge and the caller asked for a read, it reads the data field, whose length the caller chose. Last, it reads a four-bit check field and tests the whole frame by running a CRC over it and checking for a zero residue.

A controller starts a reception with a one-cycle start pulse and the requested transfer size. A single-cycle done pulse marks the end of the frame. At that pulse the tag, the slave address, the right-aligned read data and two error flags become valid, and they hold until the next frame completes. The controller decides what to do next: retry, poll or terminate.

Top module: `resp_receiver`

## Requirements
- R1: After reset the serial clock output is high, the data-line output enable is high, done and both error flags are low, and the tag, address and read data outputs are zero.
- R2: Each bit takes one serial clock pulse of HALF_CYC cycles low followed by HALF_CYC cycles high. The wire is sampled in the last cycle of the high phase, and a low wire level means a logical 1.
- R3: The start-bit hunt lasts at most HUNT_LIMIT pulses. A logical 1 seen on any of them starts the frame. If none is seen, the block sets the timeout flag, reports a clear CRC flag, and stops after exactly HUNT_LIMIT pulses.
- R4: The four bits after the start bit form the header. The first two bits are the slave address, most significant bit first. The next two are the tag, most significant bit first. Tag 0 means acknowledge, 1 busy, 2 general error and 3 a CRC error that the slave detected.
- R5: A data field follows only when the tag is 0 and the size code is nonzero. Size code 1 gives 8 bits, 2 gives 16 bits and 3 gives 32 bits. Size code 0, or any other tag, goes straight to the check field.
- R6: Data bits arrive most significant first, so the first byte received is the top byte of the value. The value is right-aligned and zero-extended in the read data output. The read data output is zero when no data field was taken.
- R7: The check field is 4 bits. A CRC with polynomial x^4+x+1 and a zero seed runs over the start bit, the header, any data and the check field. A nonzero residue raises the CRC error flag.
- R8: The data-line output enable stays low from the start pulse until the end of the frame. It is high while the block is idle.
- R9: Done is a single-cycle pulse. The outputs hold their values from that pulse until the next frame completes. A start pulse that arrives while a frame is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-cycle request to receive a response |
| size_i | input | 2 | Requested read size code: 0 none, 1 one byte, 2 two bytes, 3 four bytes |
| sda_i | input | 1 | Wire level of the serial data line (active low) |
| bus_clk_o | output | 1 | Generated serial clock, idle high |
| sda_oe_o | output | 1 | Output enable for the master's data-line driver |
| busy_o | output | 1 | A reception is in progress |
| done_o | output | 1 | One-cycle pulse when results are valid |
| id_o | output | 2 | Responding slave address |
| tag_o | output | 2 | Response tag |
| rdata_o | output | 32 | Read data, right-aligned |
| err_timeout_o | output | 1 | No start bit seen within the hunt window |
| err_crc_o | output | 1 | Nonzero CRC residue over the frame |

## Verification
The bench sweeps every combination of address, tag and size code. It varies the length of the idle gap before the start bit and counts the clock pulses in each frame. A design that sized the data field from the requested size alone, and ignored the tag, would use the wrong number of pulses and would fail the CRC check on busy and error replies. The hunt window is tested at its edge: a start bit on the last allowed pulse must be accepted, and a start bit one pulse later must give a timeout after exactly HUNT_LIMIT pulses. An off-by-one error in the hunt counter shows up in one of these two cases. Each check bit is flipped in turn. A residue check that skipped the start bit, or that dropped the received check field, would either miss these errors or flag good frames.

// File: rtl/rrx_pkg.sv
package rrx_pkg;

  localparam int ID_W   = 2;
  localparam int TAG_W  = 2;
  localparam int HDR_W  = ID_W + TAG_W;
  localparam int CRC_W  = 4;
  localparam int DATA_W = 32;
  localparam int CNT_W  = $clog2(DATA_W + 1);

  localparam logic [TAG_W-1:0] TAG_ACK = '0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HUNT,
    ST_HDR,
    ST_DATA,
    ST_CHK,
    ST_FIN
  } rx_state_e;

  // one serial step of the check code: shift left, fold the polynomial in
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                input logic b,
                                                input logic [CRC_W-1:0] poly);
    logic fb;
    fb = c[CRC_W-1] ^ b;
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
  endfunction

  // data field length for a size code (0 = no field)
  function automatic logic [CNT_W-1:0] field_bits(input logic [1:0] code);
    logic [CNT_W-1:0] n;
    case (code)
      2'd1:    n = CNT_W'(8);
      2'd2:    n = CNT_W'(16);
      2'd3:    n = CNT_W'(32);
      default: n = '0;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/rrx_pacer.sv
module rrx_pacer #(
  parameter int HALF_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic bus_clk_o,
  output logic tick_o
);
  localparam int PER  = 2 * HALF_CYC;
  localparam int PH_W = (PER > 2) ? $clog2(PER) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PER - 1);
  localparam logic [PH_W-1:0] PH_HIGH = PH_W'(HALF_CYC);

  logic [PH_W-1:0] ph_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      ph_q <= '0;
    end else if (ph_q == PH_LAST) begin
      ph_q <= '0;
    end else begin
      ph_q <= ph_q + 1'b1;
    end
  end

  // low phase first, then high; the sample point is the end of the high phase
  assign bus_clk_o = !(en && (ph_q < PH_HIGH));
  assign tick_o    = en && (ph_q == PH_LAST);

endmodule

// File: rtl/rrx_crc.sv
module rrx_crc
  import rrx_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY = 4'h3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             feed,
  input  logic             bit_i,
  output logic [CRC_W-1:0] crc_o
);
  logic [CRC_W-1:0] crc_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      crc_q <= '0;
    end else if (feed) begin
      crc_q <= crc_step(crc_q, bit_i, POLY);
    end
  end

  assign crc_o = crc_q;

endmodule

// File: rtl/rrx_shreg.sv
module rrx_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         shift,
  input  logic         bit_i,
  output logic [W-1:0] value_o
);
  logic [W-1:0] sr_q;

  generate
    if (W == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst || clear) sr_q <= '0;
        else if (shift)   sr_q <= bit_i;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst || clear) sr_q <= '0;
        else if (shift)   sr_q <= {sr_q[W-2:0], bit_i};
      end
    end
  endgenerate

  assign value_o = sr_q;

endmodule

// File: rtl/rrx_ctrl.sv
module rrx_ctrl
  import rrx_pkg::*;
#(
  parameter int HUNT_LIMIT = 1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [1:0]       size_i,
  input  logic             tick_i,
  input  logic             bit_i,
  input  logic [TAG_W-1:0] tag_now_i,
  output logic             busy_o,
  output logic             pace_en_o,
  output logic             clear_o,
  output logic             crc_feed_o,
  output logic             hdr_shift_o,
  output logic             dat_shift_o,
  output logic             fin_o,
  output logic             timeout_o
);
  localparam int HUNT_W = $clog2(HUNT_LIMIT + 1);
  localparam logic [HUNT_W-1:0] HUNT_LAST = HUNT_W'(HUNT_LIMIT - 1);
  localparam logic [CNT_W-1:0]  HDR_LAST  = CNT_W'(HDR_W - 1);
  localparam logic [CNT_W-1:0]  CHK_LAST  = CNT_W'(CRC_W - 1);

  rx_state_e        st_q;
  logic [HUNT_W-1:0] hunt_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  len_q;
  logic [1:0]        size_q;
  logic              to_q;

  always_comb begin
    busy_o      = (st_q != ST_IDLE);
    pace_en_o   = (st_q == ST_HUNT) || (st_q == ST_HDR) ||
                  (st_q == ST_DATA) || (st_q == ST_CHK);
    clear_o     = start_i && (st_q == ST_IDLE);
    hdr_shift_o = tick_i && (st_q == ST_HDR);
    dat_shift_o = tick_i && (st_q == ST_DATA);
    fin_o       = (st_q == ST_FIN);
    timeout_o   = to_q;
    case (st_q)
      ST_HUNT:                 crc_feed_o = tick_i && bit_i;
      ST_HDR, ST_DATA, ST_CHK: crc_feed_o = tick_i;
      default:                 crc_feed_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      hunt_q <= '0;
      cnt_q  <= '0;
      len_q  <= '0;
      size_q <= '0;
      to_q   <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            st_q   <= ST_HUNT;
            hunt_q <= '0;
            cnt_q  <= '0;
            size_q <= size_i;
            to_q   <= 1'b0;
          end
        end
        ST_HUNT: begin
          if (tick_i) begin
            if (bit_i) begin
              st_q  <= ST_HDR;
              cnt_q <= '0;
            end else if (hunt_q == HUNT_LAST) begin
              st_q <= ST_FIN;
              to_q <= 1'b1;
            end else begin
              hunt_q <= hunt_q + 1'b1;
            end
          end
        end
        ST_HDR: begin
          if (tick_i) begin
            if (cnt_q == HDR_LAST) begin
              cnt_q <= '0;
              // the tag just completed decides whether a data field follows
              if (tag_now_i == TAG_ACK && size_q != 2'd0) begin
                st_q  <= ST_DATA;
                len_q <= field_bits(size_q);
              end else begin
                st_q <= ST_CHK;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_DATA: begin
          if (tick_i) begin
            if (cnt_q == len_q - 1'b1) begin
              cnt_q <= '0;
              st_q  <= ST_CHK;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_CHK: begin
          if (tick_i) begin
            if (cnt_q == CHK_LAST) begin
              st_q <= ST_FIN;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_FIN:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/resp_receiver.sv
module resp_receiver
  import rrx_pkg::*;
#(
  parameter int               HALF_CYC   = 2,
  parameter int               HUNT_LIMIT = 1000,
  parameter logic [CRC_W-1:0] CRC_POLY   = 4'h3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [1:0]        size_i,
  input  logic              sda_i,
  output logic              bus_clk_o,
  output logic              sda_oe_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [ID_W-1:0]   id_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_timeout_o,
  output logic              err_crc_o
);
  logic              bit_l;
  logic              tick;
  logic              busy;
  logic              pace_en;
  logic              clr;
  logic              crc_feed;
  logic              hdr_shift;
  logic              dat_shift;
  logic              fin;
  logic              timeout;
  logic [CRC_W-1:0]  residue;
  logic [HDR_W-1:0]  hdr_val;
  logic [DATA_W-1:0] dat_val;
  logic [TAG_W-1:0]  tag_now;

  // the line is active low
  assign bit_l   = ~sda_i;
  assign tag_now = {hdr_val[0], bit_l};

  rrx_pacer #(.HALF_CYC(HALF_CYC)) pacer_i (
    .clk      (clk),
    .rst      (rst),
    .en       (pace_en),
    .bus_clk_o(bus_clk_o),
    .tick_o   (tick)
  );

  rrx_ctrl #(.HUNT_LIMIT(HUNT_LIMIT)) ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .size_i     (size_i),
    .tick_i     (tick),
    .bit_i      (bit_l),
    .tag_now_i  (tag_now),
    .busy_o     (busy),
    .pace_en_o  (pace_en),
    .clear_o    (clr),
    .crc_feed_o (crc_feed),
    .hdr_shift_o(hdr_shift),
    .dat_shift_o(dat_shift),
    .fin_o      (fin),
    .timeout_o  (timeout)
  );

  rrx_crc #(.POLY(CRC_POLY)) crc_i (
    .clk  (clk),
    .rst  (rst),
    .clear(clr),
    .feed (crc_feed),
    .bit_i(bit_l),
    .crc_o(residue)
  );

  rrx_shreg #(.W(HDR_W)) hdr_i (
    .clk    (clk),
    .rst    (rst),
    .clear  (clr),
    .shift  (hdr_shift),
    .bit_i  (bit_l),
    .value_o(hdr_val)
  );

  rrx_shreg #(.W(DATA_W)) dat_i (
    .clk    (clk),
    .rst    (rst),
    .clear  (clr),
    .shift  (dat_shift),
    .bit_i  (bit_l),
    .value_o(dat_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o        <= 1'b0;
      sda_oe_o      <= 1'b1;
      id_o          <= '0;
      tag_o         <= '0;
      rdata_o       <= '0;
      err_timeout_o <= 1'b0;
      err_crc_o     <= 1'b0;
    end else begin
      done_o   <= fin;
      sda_oe_o <= !(clr || (busy && !fin));
      if (fin) begin
        id_o          <= hdr_val[HDR_W-1 -: ID_W];
        tag_o         <= hdr_val[TAG_W-1:0];
        rdata_o       <= dat_val;
        err_timeout_o <= timeout;
        err_crc_o     <= !timeout && (residue != '0);
      end
    end
  end

  assign busy_o = busy;

endmodule

// File: rtl/resp_receiver_chk.sv
module resp_receiver_chk
  import rrx_pkg::*;
#(
  parameter int HUNT_LIMIT = 1000
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              bus_clk_o,
  input logic              sda_oe_o,
  input logic              busy_o,
  input logic              done_o,
  input logic [ID_W-1:0]   id_o,
  input logic [TAG_W-1:0]  tag_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic              err_timeout_o,
  input logic              err_crc_o
);
  localparam int MAX_PULSES = HUNT_LIMIT + HDR_W + DATA_W + CRC_W;
  localparam int PC_W       = $clog2(MAX_PULSES + 2);

  logic            clk_prev_q;
  logic [PC_W-1:0] pulses_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_prev_q <= 1'b1;
      pulses_q   <= '0;
    end else begin
      clk_prev_q <= bus_clk_o;
      if (!busy_o) pulses_q <= '0;
      else if (bus_clk_o && !clk_prev_q) pulses_q <= pulses_q + 1'b1;
    end
  end

  // R8: the driver stays off while a frame is being received
  p_oe_off_r8: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !done_o && $past(busy_o)) |-> !sda_oe_o);

  // R1: serial clock parks high when idle
  p_clk_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> bus_clk_o);

  // R9: done lasts one cycle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R9: results hold between frames
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(!busy_o) && !busy_o && !done_o) |->
      ($stable(rdata_o) && $stable(tag_o) && $stable(id_o) && $stable(err_crc_o)));

  // R3: a timeout never reports a CRC error as well
  p_err_excl_r3: assert property (@(posedge clk) disable iff (rst)
    (done_o && err_timeout_o) |-> !err_crc_o);

  // R6: no data unless acknowledged
  p_rdata_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (done_o && tag_o != TAG_ACK) |-> (rdata_o == '0));

  // R3: a frame never runs longer than the hunt window plus the longest frame
  p_pulse_bound_r3: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (pulses_q <= PC_W'(MAX_PULSES)));

endmodule

bind resp_receiver resp_receiver_chk #(.HUNT_LIMIT(HUNT_LIMIT)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .start_i      (start_i),
  .bus_clk_o    (bus_clk_o),
  .sda_oe_o     (sda_oe_o),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .id_o         (id_o),
  .tag_o        (tag_o),
  .rdata_o      (rdata_o),
  .err_timeout_o(err_timeout_o),
  .err_crc_o    (err_crc_o)
);

// File: tb/resp_receiver_tb_top.sv
module resp_receiver_tb_top;
  localparam int HALF  = 1;
  localparam int LIMIT = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [1:0]  size_i = 2'd0;
  logic        sda_i = 1'b1;
  logic        bus_clk_o, sda_oe_o, busy_o, done_o, err_timeout_o, err_crc_o;
  logic [1:0]  id_o, tag_o;
  logic [31:0] rdata_o;

  int total = 0;
  int bad = 0;
  int pulses = 0;
  int oe_bad = 0;
  int idx = 0;
  int slen = 0;
  logic stream [0:127];

  always #10 clk = ~clk;

  resp_receiver #(.HALF_CYC(HALF), .HUNT_LIMIT(LIMIT), .CRC_POLY(4'h3)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .size_i(size_i), .sda_i(sda_i),
    .bus_clk_o(bus_clk_o), .sda_oe_o(sda_oe_o), .busy_o(busy_o), .done_o(done_o),
    .id_o(id_o), .tag_o(tag_o), .rdata_o(rdata_o),
    .err_timeout_o(err_timeout_o), .err_crc_o(err_crc_o)
  );

  // slave model: next bit on each falling edge of the serial clock
  always @(negedge bus_clk_o) begin
    sda_i = (idx < slen) ? ~stream[idx] : 1'b1;
    idx++;
  end

  always @(posedge bus_clk_o) pulses++;

  always @(negedge clk) if (busy_o && sda_oe_o && !done_o) oe_bad++;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] step(input logic [3:0] c, input logic b);
    logic fb;
    fb = c[3] ^ b;
    return {c[2:0], 1'b0} ^ (fb ? 4'h3 : 4'h0);
  endfunction

  task automatic run_case(input int lead, input int id, input int tag, input int sz,
                          input logic [31:0] dat, input logic [3:0] flip, input bit exp_to);
    logic [3:0]  c;
    int          nb;
    int          w;
    int          exp_p;
    logic [31:0] exp_d;
    bit          has_d;
    has_d = (tag == 0) && (sz != 0);
    nb    = (sz == 0) ? 0 : (8 << (sz - 1));
    slen  = 0;
    c     = 4'h0;
    for (int i = 0; i < lead; i++) begin stream[slen] = 1'b0; slen++; end
    if (exp_to) begin
      stream[slen] = 1'b1; slen++;
      exp_p = LIMIT;
    end else begin
      stream[slen] = 1'b1; c = step(c, 1'b1); slen++;
      for (int b = 1; b >= 0; b--) begin stream[slen] = id[b];  c = step(c, id[b]);  slen++; end
      for (int b = 1; b >= 0; b--) begin stream[slen] = tag[b]; c = step(c, tag[b]); slen++; end
      if (has_d)
        for (int b = nb - 1; b >= 0; b--) begin stream[slen] = dat[b]; c = step(c, dat[b]); slen++; end
      for (int b = 3; b >= 0; b--) begin stream[slen] = c[b] ^ flip[b]; slen++; end
      exp_p = slen;
    end
    exp_d = has_d ? ((nb == 32) ? dat : (dat & ((32'd1 << nb) - 32'd1))) : 32'd0;
    if (exp_to) exp_d = 32'd0;
    idx = 0; sda_i = 1'b1; pulses = 0; oe_bad = 0;
    @(negedge clk); start_i = 1'b1; size_i = 2'(sz);
    @(negedge clk); start_i = 1'b0;
    w = 0;
    while (!done_o && w < 5000) begin @(negedge clk); w++; end
    if (!done_o) chk("R9 watchdog done", 64'd0, 64'd1);
    chk("R3 timeout flag", 64'(err_timeout_o), 64'(exp_to));
    chk("R5 R3 pulse count", 64'(pulses), 64'(exp_p));
    chk("R7 crc flag", 64'(err_crc_o), 64'((!exp_to) && (flip != 4'h0)));
    chk("R8 oe during frame", 64'(oe_bad), 64'd0);
    if (!exp_to) begin
      chk("R4 id", 64'(id_o), 64'(id));
      chk("R4 tag", 64'(tag_o), 64'(tag));
    end
    chk("R6 rdata", 64'(rdata_o), 64'(exp_d));
    @(negedge clk);
    chk("R9 done one cycle", 64'(done_o), 64'd0);
    chk("R8 oe idle", 64'(sda_oe_o), 64'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 bus clk", 64'(bus_clk_o), 64'd1);
    chk("R1 oe", 64'(sda_oe_o), 64'd1);
    chk("R1 done", 64'(done_o), 64'd0);
    chk("R1 errors", 64'({err_timeout_o, err_crc_o}), 64'd0);
    chk("R1 outputs", 64'({id_o, tag_o, rdata_o}), 64'd0);

    // R2 R4 R5 R6 R7: full sweep of address, tag and size
    for (int id = 0; id < 4; id++)
      for (int tag = 0; tag < 4; tag++)
        for (int sz = 0; sz < 4; sz++)
          run_case((id + tag + sz) % 4, id, tag, sz,
                   32'(32'h9E3779B9 * (id * 16 + tag * 4 + sz + 1)), 4'h0, 1'b0);

    // R7: each check bit corrupted
    for (int k = 0; k < 4; k++) run_case(1, 2, 0, 3, 32'hC0FFEE11, 4'(1 << k), 1'b0);
    run_case(0, 1, 1, 2, 32'h0, 4'h9, 1'b0);

    // R3: hunt window edges
    run_case(LIMIT - 1, 3, 0, 1, 32'h0000005A, 4'h0, 1'b0);
    run_case(LIMIT, 0, 0, 0, 32'h0, 4'h0, 1'b1);
    run_case(LIMIT + 3, 0, 0, 0, 32'h0, 4'h0, 1'b1);

    // R9: hold and ignored start while busy
    run_case(0, 2, 0, 2, 32'h0000BEEF, 4'h0, 1'b0);
    repeat (4) @(negedge clk);
    chk("R9 hold rdata", 64'(rdata_o), 64'h0000BEEF);
    chk("R9 hold id tag", 64'({id_o, tag_o}), 64'h8);
    begin
      int w;
      slen = 0; c_fill();
      idx = 0; pulses = 0;
      @(negedge clk); start_i = 1'b1; size_i = 2'd0;
      @(negedge clk); start_i = 1'b0;
      repeat (3) @(negedge clk);
      start_i = 1'b1; @(negedge clk); start_i = 1'b0;
      w = 0;
      while (!done_o && w < 5000) begin @(negedge clk); w++; end
      chk("R9 second start ignored pulses", 64'(pulses), 64'(LIMIT));
      repeat (2 * LIMIT * 2 + 8) @(negedge clk);
      chk("R9 no restart", 64'(busy_o), 64'd0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic c_fill();
    slen = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule